// File: doc/BRIEF.md
# Register-Programmed Clock Divider

This block divides a single input clock by a ratio held in a bit field of a 32-bit control word. The word is written through a one-cycle synchronous write strobe and can always be read back. The output is never gated. Each instance chooses at elaboration how the field value turns into a divide ratio: the value plus one, the value itself, two raised to the value, or a lookup in a small table in which a zero entry marks an unusable code.

A write that would produce an unusable ratio changes nothing at the output and sets a flag that stays set until reset. Legal ratios are held until the running output period ends, so a change in the ratio never cuts a pulse short. Two options are available. The first is an idle-enable bit with selectable polarity. The second is a commit mode: a new field waits in the register and only takes effect when a write also sets the commit bit.

Top module: `clkdiv_regprog`

## Requirements
- R1: After reset the readback equals `RST_FIELD << DIV_LSB`, the error flag is 0, and the output divides by the ratio that `RST_FIELD` decodes to.
- R2: In the plus-one encoding (`ENC_MINUS1`, the default) the ratio is the field value plus one. The field occupies bits `[DIV_LSB +: FW]`, and `DIV_LSB` defaults to 0.
- R3: In the direct encoding (`ENC_DIRECT`) the ratio equals the field value, and a field of 0 is an invalid setting.
- R4: In the power encoding (`ENC_POW2`) the ratio is 2 to the power of the field value.
- R5: In the table encoding (`ENC_TABLE`) the ratio is entry `field` of `TABLE`, where entry i sits at bits `[i*DW +: DW]`. A zero entry, or an index at or above `NTAB`, is an invalid setting.
- R6: In every encoding except the table, a ratio below `MIN_DIV` or above `MAX_DIV` is an invalid setting.
- R7: Committing an invalid setting sets `err_o`, which stays 1 until reset. The output ratio does not change.
- R8: For a ratio N of 2 or more, each output period starts with floor(N/2) input cycles high, followed by ceil(N/2) cycles low. For N = 1 the output follows the input clock.
- R9: A newly committed ratio takes effect only after the output period that is running has completed.
- R10: `autoidle_en_o` equals control bit `AI_BIT` XOR `AI_INV`.
- R11: With `LATCH_EN` = 1, a write with bit `LATCH_BIT` clear only updates the readback and is never checked for validity. A write with that bit set commits the field of the same write. The commit bit always reads back as 0.
- R12: The readback returns the last written word, and it changes only on a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided; also clocks the register |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 32 | Control word to write |
| rd_data_o | output | 32 | Readback of the control word |
| clk_o | output | 1 | Divided clock |
| autoidle_en_o | output | 1 | Idle-enable state after the polarity option is applied |
| err_o | output | 1 | Sticky flag: an invalid setting was committed |

## Verification
Several kinds of internal fault show up as a measured high/low split that is wrong. These include a wrong decode, a counter that never wraps, or a pending ratio that is lost. Such faults appear within one output period of the settling interval that follows a write. If a ratio were applied too early, the bench would see it in the period during which the write lands: that period would be shorter than four high and four low cycles. A flag that fails to stay set, or a commit bit that leaks into the readback, is visible on the very next sample after the write.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    // How a field value becomes a divide ratio
    typedef enum logic [1:0] {
        ENC_MINUS1 = 2'd0,
        ENC_DIRECT = 2'd1,
        ENC_POW2   = 2'd2,
        ENC_TABLE  = 2'd3
    } div_enc_e;

    localparam int unsigned CTRL_W = 32;

endpackage

// File: rtl/clkdiv_decode.sv
module clkdiv_decode
    import clkdiv_pkg::*;
#(
    parameter div_enc_e    ENC     = ENC_MINUS1,
    parameter int unsigned FW      = 5,
    parameter int unsigned DW      = 8,
    parameter int unsigned MIN_DIV = 1,
    parameter int unsigned MAX_DIV = 31,
    parameter int unsigned NTAB    = 4,
    parameter logic [NTAB*DW-1:0] TABLE = '0
) (
    input  logic [FW-1:0] field_i,
    output logic [DW-1:0] div_o,
    output logic          ok_o
);
    localparam int unsigned WW = 40;

    logic [WW-1:0] wide;
    logic          in_rng;

    generate
        if (ENC == ENC_MINUS1) begin : g_minus1
            assign wide = WW'(field_i) + WW'(1);
        end else if (ENC == ENC_DIRECT) begin : g_direct
            assign wide = WW'(field_i);
        end else if (ENC == ENC_POW2) begin : g_pow2
            // a shift past the word width yields 0, which marks it invalid
            assign wide = WW'(1) << field_i;
        end else begin : g_table
            always_comb begin
                wide = '0;
                for (int i = 0; i < int'(NTAB); i++) begin
                    if (WW'(field_i) == WW'(i)) begin
                        wide = WW'(TABLE[i*DW +: DW]);
                    end
                end
            end
        end
    endgenerate

    always_comb begin
        if (ENC == ENC_TABLE) begin
            in_rng = 1'b1;
        end else begin
            in_rng = (wide >= WW'(MIN_DIV)) && (wide <= WW'(MAX_DIV));
        end
        ok_o  = (wide != '0) && in_rng && ((wide >> DW) == '0);
        div_o = wide[DW-1:0];
    end

endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core #(
    parameter int unsigned DW = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [DW-1:0] rst_div_i,
    input  logic          load_i,
    input  logic [DW-1:0] load_div_i,
    output logic          clk_o,
    output logic [DW-1:0] cnt_o,
    output logic [DW-1:0] act_o
);
    typedef struct packed {
        logic [DW-1:0] cnt;
        logic [DW-1:0] act;
        logic [DW-1:0] pend;
        logic          pend_vld;
        logic          high;
    } core_st_t;

    core_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == st_q.act - DW'(1)) begin
            // end of period: the only place a new ratio may enter
            st_d.cnt = '0;
            if (st_q.pend_vld) begin
                st_d.act      = st_q.pend;
                st_d.pend_vld = 1'b0;
            end
        end else begin
            st_d.cnt = st_q.cnt + DW'(1);
        end
        if (load_i) begin
            st_d.pend     = load_div_i;
            st_d.pend_vld = 1'b1;
        end
        st_d.high = st_d.cnt < (st_d.act >> 1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.cnt      <= '0;
            st_q.act      <= rst_div_i;
            st_q.pend     <= '0;
            st_q.pend_vld <= 1'b0;
            st_q.high     <= (rst_div_i >> 1) != '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign clk_o = (st_q.act == DW'(1)) ? clk_i : st_q.high;
    assign cnt_o = st_q.cnt;
    assign act_o = st_q.act;

endmodule

// File: rtl/clkdiv_regprog.sv
module clkdiv_regprog
    import clkdiv_pkg::*;
#(
    parameter div_enc_e    ENC       = ENC_MINUS1,
    parameter int unsigned FW        = 5,
    parameter int unsigned DW        = 8,
    parameter int unsigned DIV_LSB   = 0,
    parameter int unsigned MIN_DIV   = 1,
    parameter int unsigned MAX_DIV   = 31,
    parameter int unsigned NTAB      = 4,
    parameter logic [NTAB*DW-1:0] TABLE = {8'd16, 8'd0, 8'd8, 8'd4},
    parameter int unsigned RST_FIELD = 1,
    parameter int unsigned AI_BIT    = 16,
    parameter bit          AI_INV    = 1'b0,
    parameter bit          LATCH_EN  = 1'b0,
    parameter int unsigned LATCH_BIT = 17
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [CTRL_W-1:0] wr_data_i,
    output logic [CTRL_W-1:0] rd_data_o,
    output logic              clk_o,
    output logic              autoidle_en_o,
    output logic              err_o
);
    localparam logic [CTRL_W-1:0] RST_WORD = CTRL_W'(RST_FIELD) << DIV_LSB;

    typedef struct packed {
        logic [CTRL_W-1:0] word;
        logic              err;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [FW-1:0] field_w;
    logic [DW-1:0] new_div, rst_div, rst_div_safe, cnt_w, act_w;
    logic          new_ok, rst_ok, commit, load;

    assign field_w = wr_data_i[DIV_LSB +: FW];

    clkdiv_decode #(
        .ENC(ENC), .FW(FW), .DW(DW), .MIN_DIV(MIN_DIV), .MAX_DIV(MAX_DIV),
        .NTAB(NTAB), .TABLE(TABLE)
    ) u_dec_wr (
        .field_i (field_w),
        .div_o   (new_div),
        .ok_o    (new_ok)
    );

    clkdiv_decode #(
        .ENC(ENC), .FW(FW), .DW(DW), .MIN_DIV(MIN_DIV), .MAX_DIV(MAX_DIV),
        .NTAB(NTAB), .TABLE(TABLE)
    ) u_dec_rst (
        .field_i (FW'(RST_FIELD)),
        .div_o   (rst_div),
        .ok_o    (rst_ok)
    );

    assign rst_div_safe = rst_ok ? rst_div : DW'(1);

    always_comb begin
        st_d   = st_q;
        commit = wr_en_i && (!LATCH_EN || wr_data_i[LATCH_BIT]);
        load   = commit && new_ok;
        if (wr_en_i) begin
            st_d.word = wr_data_i;
            if (LATCH_EN) begin
                st_d.word[LATCH_BIT] = 1'b0;
            end
        end
        if (commit && !new_ok) begin
            st_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.word <= RST_WORD;
            st_q.err  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    clkdiv_core #(.DW(DW)) u_core (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .rst_div_i  (rst_div_safe),
        .load_i     (load),
        .load_div_i (new_div),
        .clk_o      (clk_o),
        .cnt_o      (cnt_w),
        .act_o      (act_w)
    );

    assign rd_data_o     = st_q.word;
    assign autoidle_en_o = st_q.word[AI_BIT] ^ AI_INV;
    assign err_o         = st_q.err;

endmodule

// File: rtl/clkdiv_regprog_chk.sv
module clkdiv_regprog_chk #(
    parameter int unsigned DW = 8
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          wr_en_i,
    input logic [31:0]   rd_data_i,
    input logic          err_i,
    input logic [DW-1:0] cnt_i,
    input logic [DW-1:0] act_i
);
    // R7: once raised the flag holds until reset
    assert_err_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_i |=> err_i);

    // R12: readback moves only on a write
    assert_rd_stable_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_en_i |=> $stable(rd_data_i));

    // R8: the phase counter stays inside the running period
    assert_cnt_below_div_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_i < act_i);

    // R9: the applied ratio changes only at the start of a period
    assert_switch_at_wrap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(act_i) |-> cnt_i == '0);

    // R6: an applied ratio is never zero
    assert_div_nonzero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        act_i != '0);

endmodule

bind clkdiv_regprog clkdiv_regprog_chk #(.DW(DW)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .rd_data_i (rd_data_o),
    .err_i     (err_o),
    .cnt_i     (cnt_w),
    .act_i     (act_w)
);

// File: tb/test_clkdiv_regprog.sv
module test_clkdiv_regprog;
    import clkdiv_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic        rst_n;
    logic        wr_en   [4];
    logic [31:0] wr_data [4];
    logic [31:0] rd      [4];
    logic        clko    [4];
    logic        aien    [4];
    logic        err     [4];

    int n_chk  = 0;
    int n_fail = 0;

    // 0: plus-one, field at bit 0, idle bit 16
    clkdiv_regprog i_clkdiv_regprog (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en[0]), .wr_data_i(wr_data[0]),
        .rd_data_o(rd[0]), .clk_o(clko[0]), .autoidle_en_o(aien[0]), .err_o(err[0]));

    // 1: direct, field [6:4], max 6, commit bit 31, inverted idle bit 12
    clkdiv_regprog #(.ENC(ENC_DIRECT), .FW(3), .DIV_LSB(4), .MIN_DIV(1), .MAX_DIV(6),
        .RST_FIELD(2), .AI_BIT(12), .AI_INV(1'b1), .LATCH_EN(1'b1), .LATCH_BIT(31))
    i_clkdiv_regprog_dir (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en[1]), .wr_data_i(wr_data[1]),
        .rd_data_o(rd[1]), .clk_o(clko[1]), .autoidle_en_o(aien[1]), .err_o(err[1]));

    // 2: power, field [10:8], max 16
    clkdiv_regprog #(.ENC(ENC_POW2), .FW(3), .DIV_LSB(8), .MIN_DIV(1), .MAX_DIV(16),
        .RST_FIELD(0))
    i_clkdiv_regprog_pow (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en[2]), .wr_data_i(wr_data[2]),
        .rd_data_o(rd[2]), .clk_o(clko[2]), .autoidle_en_o(aien[2]), .err_o(err[2]));

    // 3: table {4, 8, 0, 16}, field [25:24]
    clkdiv_regprog #(.ENC(ENC_TABLE), .FW(2), .DIV_LSB(24), .NTAB(4),
        .TABLE({8'd16, 8'd0, 8'd8, 8'd4}), .RST_FIELD(0))
    i_clkdiv_regprog_tab (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en[3]), .wr_data_i(wr_data[3]),
        .rd_data_o(rd[3]), .clk_o(clko[3]), .autoidle_en_o(aien[3]), .err_o(err[3]));

    task automatic chk_eq(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic write(input int k, input logic [31:0] d);
        @(negedge clk);
        wr_en[k]   = 1'b1;
        wr_data[k] = d;
        @(negedge clk);
        wr_en[k]   = 1'b0;
    endtask

    task automatic measure(input int k, output int hi, output int lo);
        int   guard = 0;
        logic prev, cur;
        @(negedge clk);
        cur = clko[k];
        do begin
            prev = cur;
            @(negedge clk);
            cur = clko[k];
            guard++;
        end while (!(prev == 1'b0 && cur == 1'b1) && guard < 200);
        hi = 1;
        @(negedge clk);
        while (clko[k] == 1'b1 && guard < 400) begin hi++; @(negedge clk); guard++; end
        lo = 0;
        while (clko[k] == 1'b0 && guard < 400) begin lo++; @(negedge clk); guard++; end
    endtask

    task automatic chk_bypass(input int k, input string tag);
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #5;
            chk_eq({tag, " mid-high"}, clko[k], 1);
            @(negedge clk); #5;
            chk_eq({tag, " mid-low"}, clko[k], 0);
        end
    endtask

    // scoreboard
    typedef struct {
        int    k;
        int    hi;
        int    lo;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    bit   mon_busy = 1'b0;

    task automatic expect_period(input int k, input int hi, input int lo, input string tag);
        exp_t e;
        repeat (40) @(negedge clk);
        e.k = k; e.hi = hi; e.lo = lo; e.tag = tag;
        exp_q.push_back(e);
        wait (exp_q.size() == 0 && !mon_busy);
    endtask

    initial begin : monitor
        exp_t e;
        int   hi, lo;
        forever begin
            wait (exp_q.size() > 0);
            mon_busy = 1'b1;
            e = exp_q.pop_front();
            measure(e.k, hi, lo);
            chk_eq({e.tag, " high cycles"}, hi, e.hi);
            chk_eq({e.tag, " low cycles"}, lo, e.lo);
            mon_busy = 1'b0;
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : driver
        int   h, l;
        logic prev, cur;
        for (int i = 0; i < 4; i++) begin wr_en[i] = 1'b0; wr_data[i] = '0; end
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk_eq("R1 rd plus-one", rd[0], 1);
        chk_eq("R1 rd direct", rd[1], 32'h20);
        chk_eq("R1 rd power", rd[2], 0);
        chk_eq("R1 rd table", rd[3], 0);
        for (int i = 0; i < 4; i++) chk_eq("R1 err", err[i], 0);
        chk_eq("R10 idle plain reset", aien[0], 0);
        chk_eq("R10 idle inverted reset", aien[1], 1);
        expect_period(0, 1, 1, "R1 reset ratio 2");
        expect_period(3, 2, 2, "R1 R5 reset ratio 4");
        chk_bypass(2, "R1 R8 reset ratio 1");

        // R2 / R8: plus-one encoding, odd and even
        write(0, 32'd4);
        chk_eq("R12 readback", rd[0], 4);
        expect_period(0, 2, 3, "R2 R8 ratio 5");
        write(0, 32'd7);
        expect_period(0, 4, 4, "R2 ratio 8");
        write(0, 32'h0001_0007);
        chk_eq("R10 idle plain set", aien[0], 1);
        chk_eq("R12 readback full word", rd[0], 32'h0001_0007);
        expect_period(0, 4, 4, "R2 ratio 8 kept");

        // R9: change lands mid-period, old period finishes whole
        cur = clko[0];
        do begin prev = cur; @(negedge clk); cur = clko[0]; end
        while (!(prev == 1'b0 && cur == 1'b1));
        wr_en[0] = 1'b1; wr_data[0] = 32'd1;
        h = 1;
        @(negedge clk);
        wr_en[0] = 1'b0;
        while (clko[0] == 1'b1 && h < 50) begin h++; @(negedge clk); end
        l = 0;
        while (clko[0] == 1'b0 && l < 50) begin l++; @(negedge clk); end
        chk_eq("R9 old period high", h, 4);
        chk_eq("R9 old period low", l, 4);
        @(negedge clk);
        chk_eq("R9 new ratio 2 low", clko[0], 0);
        @(negedge clk);
        chk_eq("R9 new ratio 2 high", clko[0], 1);

        // R8 ratio 1; R6 / R7 out-of-range keeps it
        write(0, 32'd0);
        repeat (40) @(negedge clk);
        chk_bypass(0, "R8 ratio 1");
        write(0, 32'd31);
        chk_eq("R6 R7 err after 32 > max", err[0], 1);
        repeat (40) @(negedge clk);
        chk_bypass(0, "R7 ratio kept");
        write(0, 32'd2);
        expect_period(0, 1, 2, "R8 ratio 3");
        chk_eq("R7 err sticky", err[0], 1);

        // R11 / R3: commit mode, direct encoding
        write(1, 32'h30);
        chk_eq("R11 staged readback", rd[1], 32'h30);
        expect_period(1, 1, 1, "R11 staged not applied");
        write(1, 32'h8000_0030);
        chk_eq("R11 commit bit reads 0", rd[1], 32'h30);
        expect_period(1, 1, 2, "R3 ratio 3");
        write(1, 32'h0000_1000);
        chk_eq("R11 staged zero no err", err[1], 0);
        chk_eq("R10 idle inverted set", aien[1], 0);
        write(1, 32'h8000_0000);
        chk_eq("R3 zero invalid", err[1], 1);
        expect_period(1, 1, 2, "R3 R7 ratio kept");
        write(1, 32'h8000_0060);
        expect_period(1, 3, 3, "R3 ratio 6");

        // R4 / R6: power encoding
        write(2, 32'h200);
        expect_period(2, 2, 2, "R4 ratio 4");
        write(2, 32'h300);
        expect_period(2, 4, 4, "R4 ratio 8");
        chk_eq("R4 no err", err[2], 0);
        write(2, 32'h500);
        chk_eq("R6 32 above max", err[2], 1);
        expect_period(2, 4, 4, "R6 ratio kept");

        // R5: table encoding with a hole
        write(3, 32'h0300_0000);
        expect_period(3, 8, 8, "R5 entry 3 ratio 16");
        write(3, 32'h0200_0000);
        chk_eq("R5 hole invalid", err[3], 1);
        expect_period(3, 8, 8, "R5 ratio kept");
        write(3, 32'h0100_0000);
        expect_period(3, 4, 4, "R5 entry 1 ratio 8");
        chk_eq("R12 readback idle", rd[3], 32'h0100_0000);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule